// File: doc/BRIEF.md
# Serial Memory Page Write and Address Controller

This block sits behind a two-wire serial bus engine and owns the word address and the write path of a 1024 x 8 storage array. The array is split into 64 pages of 16 bytes. The bus engine sends one-cycle requests to the block. One request loads a new address. One stores an incoming data byte in a 16-entry page buffer. One reads the byte at the current address and moves the address on. One commits the buffered bytes when a stop condition arrives, and one discards them. The array itself is a plain synchronous RAM.

The address follows two different rules. When writing, only the low four bits count, so the address cycles inside one page. When reading, all ten bits count, so the address runs through the whole array and wraps from the top back to zero. Each buffer slot has its own valid flag. A commit therefore changes only the bytes that were actually received.

A commit starts an internally timed write cycle of `WR_CYCLES` clocks. The controller reports this cycle on `busy`, copies the valid slots into the array, and ignores every request until the cycle ends. If the write-protect input is high when the commit arrives, the buffered bytes are thrown away, the array is left unchanged, and `busy` never rises.

Top module: `eep_page_ctrl`

## Requirements
- R1: After reset, `busy` and `rd_valid` are low and `cur_addr` is 0.
- R2: A load request while idle sets `cur_addr` to `load_addr` on the next cycle.
- R3: A data-byte request while idle stores the byte in the slot selected by `cur_addr[3:0]`, then adds one to `cur_addr[3:0]` only. Bits 9:4 are kept, so 0x7F is followed by 0x70.
- R4: If more than 16 bytes arrive before a commit, the address cycles through the page again. A later byte replaces the earlier byte held in the same slot, and only the later byte reaches the array.
- R5: A commit writes only the slots that received a byte since the last commit or abort. All other locations of the page keep their contents.
- R6: A read request while idle puts the array byte at `cur_addr` on `rd_data`, with `rd_valid` high for exactly the next cycle. The full 10-bit `cur_addr` then increments, wrapping from 1023 to 0.
- R7: A commit while idle, with write protect low and at least one valid slot, raises `busy` on the next cycle. `busy` then stays high for exactly `WR_CYCLES` cycles.
- R8: A commit with write protect high leaves the array unchanged, never raises `busy`, and clears all valid slots.
- R9: While `busy` is high, load, data, read, commit and abort requests have no effect: `cur_addr` holds and `rd_valid` stays low.
- R10: A commit with no valid slots does not raise `busy`.
- R11: An abort request clears every valid slot, so a following commit writes nothing and does not raise `busy`.
- R12: Between operations `cur_addr` holds the last accessed address plus one (with the wrap rule of that access). A later read with no load returns the byte at that location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_req | input | 1 | Load `load_addr` into the address counter |
| load_addr | input | 10 | New word address |
| wr_req | input | 1 | Store `wr_byte` in the page buffer |
| wr_byte | input | 8 | Data byte to buffer |
| rd_req | input | 1 | Read the byte at the current address and advance |
| commit_req | input | 1 | Stop seen: start the write cycle |
| abort_req | input | 1 | Discard the buffered bytes |
| wp | input | 1 | Write protect; high blocks every commit |
| busy | output | 1 | Write cycle in progress |
| cur_addr | output | 10 | Current word address |
| rd_data | output | 8 | Byte returned by a read |
| rd_valid | output | 1 | `rd_data` is valid this cycle |

## Verification
The checker assumes that the bus engine raises at most one request per cycle. Its address properties are written with the block's fixed priority (load, then data, then read, then commit, then abort), so they stay exact even if two requests overlap. The bench drives every request as a single-cycle pulse, one at a time, on the falling edge. It changes `wp` only while no request is active. It sends requests during `busy` only in the scenario that checks they are ignored.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [2:0] {
      OP_IDLE   = 3'd0,
      OP_LOAD   = 3'd1,
      OP_WRITE  = 3'd2,
      OP_READ   = 3'd3,
      OP_COMMIT = 3'd4,
      OP_ABORT  = 3'd5
   } op_e;
endpackage

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr
   import eep_pkg::*;
#(
   parameter int AW = 10,
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  op_e           op,
   input  logic [AW-1:0] load_addr,
   output logic [AW-1:0] addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else begin
         case (op)
            OP_LOAD:  addr <= load_addr;
            // write: only the in-page bits roll
            OP_WRITE: addr <= {addr[AW-1:PW], addr[PW-1:0] + PW'(1)};
            // read: the whole address rolls
            OP_READ:  addr <= addr + AW'(1);
            default:  addr <= addr;
         endcase
      end
   end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
   parameter int PW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [PW-1:0] wr_slot,
   input  logic [DW-1:0] wr_data,
   input  logic          clr,
   input  logic [PW-1:0] rd_slot,
   output logic [DW-1:0] rd_byte,
   output logic          rd_vld,
   output logic          any_vld
);
   localparam int SLOTS = 1 << PW;

   logic [DW-1:0]    slot_data [SLOTS];
   logic [SLOTS-1:0] slot_vld;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [DW-1:0] d_q;
      logic          v_q;
      logic          hit;

      assign hit = wr_en && (wr_slot == PW'(g));

      always_ff @(posedge clk) begin
         if (hit) d_q <= wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   v_q <= 1'b0;
         else if (clr) v_q <= 1'b0;
         else if (hit) v_q <= 1'b1;
      end

      assign slot_data[g] = d_q;
      assign slot_vld[g]  = v_q;
   end

   assign rd_byte = slot_data[rd_slot];
   assign rd_vld  = slot_vld[rd_slot];
   assign any_vld = |slot_vld;
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
   parameter int WR_CYCLES  = 200_000,
   parameter int PAGE_BYTES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic drain,
   output logic [$clog2(PAGE_BYTES)-1:0] idx,
   output logic done
);
   localparam int TW = $clog2(WR_CYCLES + 1);
   localparam int IW = $clog2(PAGE_BYTES);

   logic [TW-1:0] cnt;

   assign done  = busy && (cnt == TW'(WR_CYCLES - 1));
   assign drain = busy && (cnt < TW'(PAGE_BYTES));
   assign idx   = cnt[IW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (busy) begin
         cnt <= cnt + TW'(1);
         if (done) busy <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end
   end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int AW = 10,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
   import eep_pkg::*;
#(
   parameter int AW        = 10,
   parameter int PW        = 4,
   parameter int DW        = 8,
   parameter int WR_CYCLES = 200_000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_req,
   input  logic [AW-1:0] load_addr,
   input  logic          wr_req,
   input  logic [DW-1:0] wr_byte,
   input  logic          rd_req,
   input  logic          commit_req,
   input  logic          abort_req,
   input  logic          wp,
   output logic          busy,
   output logic [AW-1:0] cur_addr,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid
);
   localparam int PAGE_BYTES = 1 << PW;
   localparam int ROW_W      = AW - PW;

   if (PW < 1 || PW >= AW) begin : g_bad_pw
      $error("eep_page_ctrl: PW must lie between 1 and AW-1");
   end
   if (WR_CYCLES < PAGE_BYTES) begin : g_bad_wr
      $error("eep_page_ctrl: WR_CYCLES must cover one page drain");
   end

   op_e            op;
   logic           start, clr, done, drain;
   logic           any_vld, slot_vld;
   logic [PW-1:0]  idx;
   logic [DW-1:0]  slot_byte;
   logic [ROW_W-1:0] row_q;

   always_comb begin
      op = OP_IDLE;
      if (!busy) begin
         if (load_req)        op = OP_LOAD;
         else if (wr_req)     op = OP_WRITE;
         else if (rd_req)     op = OP_READ;
         else if (commit_req) op = OP_COMMIT;
         else if (abort_req)  op = OP_ABORT;
      end
   end

   assign start = (op == OP_COMMIT) && any_vld && !wp;
   assign clr   = ((op == OP_COMMIT) && !start) || (op == OP_ABORT) || done;

   eep_addr_ctr #(.AW(AW), .PW(PW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .op(op), .load_addr(load_addr), .addr(cur_addr)
   );

   eep_page_buf #(.PW(PW), .DW(DW)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(op == OP_WRITE), .wr_slot(cur_addr[PW-1:0]), .wr_data(wr_byte),
      .clr(clr), .rd_slot(idx),
      .rd_byte(slot_byte), .rd_vld(slot_vld), .any_vld(any_vld)
   );

   eep_wr_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .drain(drain), .idx(idx), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     row_q <= '0;
      else if (start) row_q <= cur_addr[AW-1:PW];
   end

   eep_array #(.AW(AW), .DW(DW)) u_mem (
      .clk(clk),
      .we(drain && slot_vld), .waddr({row_q, idx}), .wdata(slot_byte),
      .re(op == OP_READ), .raddr(cur_addr), .rdata(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= (op == OP_READ);
   end
endmodule

// File: rtl/eep_page_ctrl_chk.sv
module eep_page_ctrl_chk #(
   parameter int AW        = 10,
   parameter int PW        = 4,
   parameter int DW        = 8,
   parameter int WR_CYCLES = 200_000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          load_req,
   input logic [AW-1:0] load_addr,
   input logic          wr_req,
   input logic          rd_req,
   input logic          commit_req,
   input logic          wp,
   input logic          busy,
   input logic [AW-1:0] cur_addr,
   input logic          rd_valid
);
   localparam int CW = $clog2(WR_CYCLES + 2);

   logic [CW-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cnt <= '0;
      else if (busy) busy_cnt <= busy_cnt + CW'(1);
      else           busy_cnt <= '0;
   end

   // R2
   load_sets_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_req && !busy |=> cur_addr == $past(load_addr));

   // R3
   page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && !load_req && !busy |=>
         (cur_addr[AW-1:PW] == $past(cur_addr[AW-1:PW])) &&
         (cur_addr[PW-1:0] == PW'($past(cur_addr[PW-1:0]) + PW'(1))));

   // R6
   read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !load_req && !wr_req && !busy |=>
         rd_valid && (cur_addr == AW'($past(cur_addr) + AW'(1))));

   // R7
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_cnt == CW'(WR_CYCLES));

   // R7
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> busy_cnt < CW'(WR_CYCLES));

   // R8
   protect_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req && wp && !busy && !load_req && !wr_req && !rd_req |=> !busy);

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cur_addr) && !rd_valid);
endmodule

bind eep_page_ctrl eep_page_ctrl_chk #(
   .AW(AW), .PW(PW), .DW(DW), .WR_CYCLES(WR_CYCLES)
) u_chk (.*);

// File: tb/eep_page_ctrl_bench.sv
module eep_page_ctrl_bench;
   localparam int AW  = 10;
   localparam int PW  = 4;
   localparam int DW  = 8;
   localparam int WRC = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_req = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic          wr_req = 1'b0;
   logic [DW-1:0] wr_byte = '0;
   logic          rd_req = 1'b0;
   logic          commit_req = 1'b0;
   logic          abort_req = 1'b0;
   logic          wp = 1'b0;
   logic          busy;
   logic [AW-1:0] cur_addr;
   logic [DW-1:0] rd_data;
   logic          rd_valid;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   eep_page_ctrl #(.AW(AW), .PW(PW), .DW(DW), .WR_CYCLES(WRC)) u_eep_page_ctrl (.*);

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_load(logic [AW-1:0] a);
      @(negedge clk); load_req = 1'b1; load_addr = a;
      @(negedge clk); load_req = 1'b0;
   endtask

   task automatic do_write(logic [DW-1:0] b);
      @(negedge clk); wr_req = 1'b1; wr_byte = b;
      @(negedge clk); wr_req = 1'b0;
   endtask

   task automatic do_read(string req, logic [DW-1:0] exp);
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      chk(req, int'(rd_valid), 1);
      chk(req, int'(rd_data), int'(exp));
   endtask

   task automatic do_abort();
      @(negedge clk); abort_req = 1'b1;
      @(negedge clk); abort_req = 1'b0;
   endtask

   // commit and count the cycles busy stays high
   task automatic do_commit(string req, int exp_len);
      int n = 0;
      @(negedge clk); commit_req = 1'b1;
      @(negedge clk); commit_req = 1'b0;
      while (busy && n < 10 * WRC) begin
         n++;
         @(negedge clk);
      end
      chk(req, n, exp_len);
   endtask

   task automatic t_reset();
      chk("R1 busy", int'(busy), 0);
      chk("R1 rd_valid", int'(rd_valid), 0);
      chk("R1 cur_addr", int'(cur_addr), 0);
   endtask

   task automatic t_full_page();
      do_load(10'h050);
      chk("R2 load", int'(cur_addr), 'h050);
      for (int i = 0; i < 16; i++) do_write(8'(8'hA0 + i));
      chk("R3 after 16 bytes", int'(cur_addr), 'h050);
      do_commit("R7 busy length", WRC);
      for (int i = 0; i < 16; i++) do_read("R6 page readback", 8'(8'hA0 + i));
      chk("R12 addr after read", int'(cur_addr), 'h060);
   endtask

   task automatic t_page_wrap();
      do_load(10'h07E);
      do_write(8'h11);
      chk("R3 step", int'(cur_addr), 'h07F);
      do_write(8'h22);
      chk("R3 in-page wrap", int'(cur_addr), 'h070);
      do_write(8'h33);
      chk("R3 step after wrap", int'(cur_addr), 'h071);
      do_commit("R7 busy length", WRC);
      do_load(10'h07E);
      do_read("R3 byte 7E", 8'h11);
      do_read("R3 byte 7F", 8'h22);
      chk("R6 read crosses page", int'(cur_addr), 'h080);
      do_load(10'h070);
      do_read("R3 byte 70", 8'h33);
   endtask

   task automatic t_overflow();
      do_load(10'h080);
      for (int i = 0; i < 18; i++) do_write(8'(8'h10 + i));
      do_commit("R7 busy length", WRC);
      do_load(10'h080);
      do_read("R4 overwritten slot 0", 8'h20);
      do_read("R4 overwritten slot 1", 8'h21);
      do_read("R4 kept slot 2", 8'h12);
   endtask

   task automatic t_partial();
      do_load(10'h053);
      do_write(8'hC0);
      do_write(8'hC1);
      chk("R12 addr after write", int'(cur_addr), 'h055);
      do_commit("R7 busy length", WRC);
      do_read("R12 current-address read", 8'hA5);
      do_load(10'h052);
      do_read("R5 untouched 52", 8'hA2);
      do_read("R5 written 53", 8'hC0);
      do_read("R5 written 54", 8'hC1);
      do_read("R5 untouched 55", 8'hA5);
   endtask

   task automatic t_protect();
      do_load(10'h050);
      do_write(8'hEE);
      @(negedge clk); wp = 1'b1;
      do_commit("R8 no busy under protect", 0);
      @(negedge clk); wp = 1'b0;
      do_commit("R10 flags cleared, no busy", 0);
      do_load(10'h050);
      do_read("R8 array unchanged", 8'hA0);
   endtask

   task automatic t_abort();
      do_commit("R10 empty commit", 0);
      do_load(10'h051);
      do_write(8'h77);
      do_abort();
      do_commit("R11 commit after abort", 0);
      do_load(10'h051);
      do_read("R11 array unchanged", 8'hA1);
   endtask

   task automatic t_read_wrap();
      do_load(10'h3FF);
      do_write(8'h5A);
      do_commit("R7 busy length", WRC);
      do_load(10'h000);
      do_write(8'h3C);
      do_commit("R7 busy length", WRC);
      do_load(10'h3FF);
      do_read("R6 top byte", 8'h5A);
      chk("R6 wrap to zero", int'(cur_addr), 0);
      do_read("R6 byte zero", 8'h3C);
      chk("R6 step after wrap", int'(cur_addr), 1);
   endtask

   task automatic t_busy_ignore();
      do_load(10'h0A0);
      do_write(8'h99);
      @(negedge clk); commit_req = 1'b1;
      @(negedge clk); commit_req = 1'b0;
      chk("R7 busy rises", int'(busy), 1);
      load_req = 1'b1; load_addr = 10'h200;
      @(negedge clk); load_req = 1'b0;
      chk("R9 load ignored", int'(cur_addr), 'h0A1);
      wr_req = 1'b1; wr_byte = 8'h44;
      @(negedge clk); wr_req = 1'b0;
      chk("R9 write ignored", int'(cur_addr), 'h0A1);
      rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      chk("R9 read ignored", int'(rd_valid), 0);
      chk("R9 read no step", int'(cur_addr), 'h0A1);
      while (busy) @(negedge clk);
      chk("R9 addr kept", int'(cur_addr), 'h0A1);
      do_load(10'h0A0);
      do_read("R9 committed byte", 8'h99);
      do_commit("R9 busy-time write dropped", 0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50_000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=done", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_page();
      t_page_wrap();
      t_overflow();
      t_partial();
      t_protect();
      t_abort();
      t_read_wrap();
      t_busy_ignore();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule